// File: doc/BRIEF.md
# Locality Access Arbiter

This block is the host-side controller that claims and gives up locality 0 of a trusted-module register interface. It talks to the module through one byte-wide access register, using a simple read/write port toward the module. After reset it reads that register repeatedly until the module reports that its bits are valid. It then serves two commands from the host: acquire and release.

An acquire first reads the register. If the module already reports the locality as valid and active, the block grants at once and writes nothing. Otherwise it writes a request, then keeps reading at a fixed cycle interval until the locality turns active. If that does not happen before a cycle timeout runs out, it reports busy. An acquire for any locality other than 0 is refused with an invalid-locality flag. A release reads the register and gives up the locality only when another party has a request pending and the bits are valid; in every other case it changes nothing. A command that arrives while the block is working is held in a one-deep slot and runs once the block is idle.

Access register bits used: 0x80 valid, 0x20 locality active, 0x04 request pending from another party, 0x02 request to use.

Top module: `tis_loc_arbiter`

## Requirements
- R1: In reset and in the first cycles after it, `granted`, `busy_err`, `inval_err` and `done` are all 0.
- R2: After reset the block reads the access register (one read every POLL_GAP+2 cycles at most) and writes nothing until a response has bit 0x80 set. Host commands given during this phase are held and run afterwards. If STARTUP_TRIES reads in a row show 0x80 clear, `busy_err` goes to 1 and the block goes idle after exactly STARTUP_TRIES reads.
- R3: An acquire whose `cmd_loc` is not 0 sets `inval_err`, pulses `done`, performs no register access and leaves `granted` unchanged.
- R4: An acquire for locality 0 whose first read shows both 0x80 and 0x20 sets `granted` and pulses `done` without any write.
- R5: Otherwise the block writes 0x02 once, then reads again every POLL_GAP+2 cycles; the first read showing both 0x80 and 0x20 sets `granted` and pulses `done`.
- R6: If no such read comes within TIMEOUT_CYC cycles of the 0x02 write, the block sets `busy_err`, clears `granted` and pulses `done`.
- R7: A release reads the register. If 0x04 and 0x80 are both set it writes 0x20 and clears `granted`; otherwise it writes nothing and `granted` keeps its value. Either way `done` pulses.
- R8: A command given while the block is busy is held and runs after the current one. While one command is held, further commands are dropped. If acquire and release are given in the same cycle, only the acquire is taken.
- R9: `busy_err` and `inval_err` return to 0 when the next command is taken; `done` pulses once per completed command.
- R10: The block never reads and writes in the same cycle, never starts a read while one is outstanding, and only ever writes 0x02 or 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_acquire | input | 1 | One-cycle acquire command |
| cmd_release | input | 1 | One-cycle release command |
| cmd_loc | input | LOC_W | Locality for the acquire command |
| acc_rd | output | 1 | Read strobe for the access register |
| acc_wr | output | 1 | Write strobe for the access register |
| acc_wdata | output | 8 | Write data for the access register |
| acc_rdata | input | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | input | 1 | Read response strobe |
| granted | output | 1 | Locality 0 is held by this host |
| busy_err | output | 1 | Last acquire timed out, or startup never saw valid |
| inval_err | output | 1 | Last acquire named a locality other than 0 |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
A wrong state register would show first on the access port: a write of 0x02 where the register already read active, a write of 0x20 without a pending request, or a read and write in the same cycle, each visible in the cycle the wrong state is entered. A broken counter shows up as a wrong number of startup reads, or as a timeout that ends too early or too late compared to TIMEOUT_CYC measured from the request write. A broken hold slot shows up as a missing or extra `done` pulse within a few cycles of the command that should have been held or dropped.

// File: rtl/tis_loc_pkg.sv
package tis_loc_pkg;
   localparam logic [7:0] ACC_VALID   = 8'h80;
   localparam logic [7:0] ACC_ACTIVE  = 8'h20;
   localparam logic [7:0] ACC_PENDING = 8'h04;
   localparam logic [7:0] ACC_REQUEST = 8'h02;
   localparam logic [7:0] ACC_OWNED   = ACC_VALID | ACC_ACTIVE;
   localparam logic [7:0] ACC_YIELD   = ACC_VALID | ACC_PENDING;

   typedef enum logic [3:0] {
      ST_BOOT_RD,
      ST_BOOT_WT,
      ST_BOOT_GAP,
      ST_IDLE,
      ST_ACQ_RD,
      ST_ACQ_WT,
      ST_ACQ_WR,
      ST_POLL_GAP,
      ST_POLL_RD,
      ST_POLL_WT,
      ST_REL_RD,
      ST_REL_WT,
      ST_REL_WR
   } loc_state_e;
endpackage

// File: rtl/loc_down_cnt.sv
module loc_down_cnt #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= W'(RST_VAL);
      else if (load)             cnt <= load_val;
      else if (dec && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/loc_cmd_hold.sv
module loc_cmd_hold #(
   parameter int LOC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acq_in,
   input  logic             rel_in,
   input  logic [LOC_W-1:0] loc_in,
   input  logic             take,
   output logic             held,
   output logic             held_acq,
   output logic [LOC_W-1:0] held_loc
);
   // one-deep slot; acquire wins a same-cycle tie; new commands dropped while full
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held     <= 1'b0;
         held_acq <= 1'b0;
         held_loc <= '0;
      end else if (!held || take) begin
         held     <= acq_in | rel_in;
         held_acq <= acq_in;
         held_loc <= loc_in;
      end
   end
endmodule

// File: rtl/tis_loc_arbiter.sv
module tis_loc_arbiter
   import tis_loc_pkg::*;
#(
   parameter int LOC_W         = 3,
   parameter int POLL_GAP      = 16,
   parameter int TIMEOUT_CYC   = 2000,
   parameter int STARTUP_TRIES = 10000,
   parameter bit STARTUP_POLL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_acquire,
   input  logic             cmd_release,
   input  logic [LOC_W-1:0] cmd_loc,
   output logic             acc_rd,
   output logic             acc_wr,
   output logic [7:0]       acc_wdata,
   input  logic [7:0]       acc_rdata,
   input  logic             acc_rvalid,
   output logic             granted,
   output logic             busy_err,
   output logic             inval_err,
   output logic             done
);
   localparam int GAP_W = $clog2(POLL_GAP + 1);
   localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
   localparam int TRY_W = $clog2(STARTUP_TRIES + 1);
   localparam loc_state_e ST_FIRST = STARTUP_POLL ? ST_BOOT_RD : ST_IDLE;

   generate
      if (LOC_W < 1)              begin : g_bad_loc  $error("LOC_W must be at least 1"); end
      if (POLL_GAP < 1)           begin : g_bad_gap  $error("POLL_GAP must be at least 1"); end
      if (TIMEOUT_CYC < POLL_GAP) begin : g_bad_tmo  $error("TIMEOUT_CYC below POLL_GAP"); end
      if (STARTUP_TRIES < 1)      begin : g_bad_try  $error("STARTUP_TRIES must be at least 1"); end
   endgenerate

   loc_state_e st, nxt;

   logic             held, held_acq, take;
   logic [LOC_W-1:0] held_loc;
   logic             gap_load, gap_zero, gap_dec;
   logic             tmo_load, tmo_zero;
   logic             boot_dec, boot_zero;
   logic             set_grant, clr_grant, set_busy, set_inval, clr_flags, fin;
   logic             rsp_owned, rsp_yield, rsp_valid;

   assign rsp_owned = (acc_rdata & ACC_OWNED) == ACC_OWNED;
   assign rsp_yield = (acc_rdata & ACC_YIELD) == ACC_YIELD;
   assign rsp_valid = (acc_rdata & ACC_VALID) == ACC_VALID;
   assign gap_dec   = (st == ST_BOOT_GAP) || (st == ST_POLL_GAP);

   loc_cmd_hold #(.LOC_W(LOC_W)) i_hold (
      .clk(clk), .rst_n(rst_n),
      .acq_in(cmd_acquire), .rel_in(cmd_release), .loc_in(cmd_loc),
      .take(take), .held(held), .held_acq(held_acq), .held_loc(held_loc)
   );

   loc_down_cnt #(.W(GAP_W), .RST_VAL(0)) i_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load),
      .load_val(GAP_W'(POLL_GAP - 1)), .dec(gap_dec), .zero(gap_zero)
   );

   loc_down_cnt #(.W(TMO_W), .RST_VAL(0)) i_tmo (
      .clk(clk), .rst_n(rst_n), .load(tmo_load),
      .load_val(TMO_W'(TIMEOUT_CYC)), .dec(1'b1), .zero(tmo_zero)
   );

   generate
      if (STARTUP_POLL) begin : g_boot
         loc_down_cnt #(.W(TRY_W), .RST_VAL(STARTUP_TRIES - 1)) i_boot (
            .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
            .dec(boot_dec), .zero(boot_zero)
         );
      end else begin : g_noboot
         assign boot_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt       = st;
      acc_rd    = 1'b0;
      acc_wr    = 1'b0;
      acc_wdata = 8'h00;
      take      = 1'b0;
      gap_load  = 1'b0;
      tmo_load  = 1'b0;
      boot_dec  = 1'b0;
      set_grant = 1'b0;
      clr_grant = 1'b0;
      set_busy  = 1'b0;
      set_inval = 1'b0;
      clr_flags = 1'b0;
      fin       = 1'b0;
      case (st)
         ST_BOOT_RD: begin
            acc_rd = 1'b1;
            nxt    = ST_BOOT_WT;
         end
         ST_BOOT_WT: if (acc_rvalid) begin
            if (rsp_valid) nxt = ST_IDLE;
            else if (boot_zero) begin
               set_busy = 1'b1;
               nxt      = ST_IDLE;
            end else begin
               boot_dec = 1'b1;
               gap_load = 1'b1;
               nxt      = ST_BOOT_GAP;
            end
         end
         ST_BOOT_GAP: if (gap_zero) nxt = ST_BOOT_RD;
         ST_IDLE: if (held) begin
            take      = 1'b1;
            clr_flags = 1'b1;
            if (!held_acq)           nxt = ST_REL_RD;
            else if (held_loc != '0) begin
               set_inval = 1'b1;
               fin       = 1'b1;
            end else                 nxt = ST_ACQ_RD;
         end
         ST_ACQ_RD: begin
            acc_rd = 1'b1;
            nxt    = ST_ACQ_WT;
         end
         ST_ACQ_WT: if (acc_rvalid) begin
            if (rsp_owned) begin
               set_grant = 1'b1;
               fin       = 1'b1;
               nxt       = ST_IDLE;
            end else nxt = ST_ACQ_WR;
         end
         ST_ACQ_WR: begin
            acc_wr    = 1'b1;
            acc_wdata = ACC_REQUEST;
            tmo_load  = 1'b1;
            gap_load  = 1'b1;
            nxt       = ST_POLL_GAP;
         end
         ST_POLL_GAP: if (gap_zero) nxt = ST_POLL_RD;
         ST_POLL_RD: begin
            acc_rd = 1'b1;
            nxt    = ST_POLL_WT;
         end
         ST_POLL_WT: if (acc_rvalid) begin
            if (rsp_owned) begin
               set_grant = 1'b1;
               fin       = 1'b1;
               nxt       = ST_IDLE;
            end else if (tmo_zero) begin
               set_busy  = 1'b1;
               clr_grant = 1'b1;
               fin       = 1'b1;
               nxt       = ST_IDLE;
            end else begin
               gap_load = 1'b1;
               nxt      = ST_POLL_GAP;
            end
         end
         ST_REL_RD: begin
            acc_rd = 1'b1;
            nxt    = ST_REL_WT;
         end
         ST_REL_WT: if (acc_rvalid) begin
            if (rsp_yield) nxt = ST_REL_WR;
            else begin
               fin = 1'b1;
               nxt = ST_IDLE;
            end
         end
         ST_REL_WR: begin
            acc_wr    = 1'b1;
            acc_wdata = ACC_ACTIVE;
            clr_grant = 1'b1;
            fin       = 1'b1;
            nxt       = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_FIRST;
         granted   <= 1'b0;
         busy_err  <= 1'b0;
         inval_err <= 1'b0;
         done      <= 1'b0;
      end else begin
         st   <= nxt;
         done <= fin;
         if (set_grant)      granted <= 1'b1;
         else if (clr_grant) granted <= 1'b0;
         if (set_busy)       busy_err <= 1'b1;
         else if (clr_flags) busy_err <= 1'b0;
         if (set_inval)      inval_err <= 1'b1;
         else if (clr_flags) inval_err <= 1'b0;
      end
   end
endmodule

// File: rtl/tis_loc_arbiter_chk.sv
module tis_loc_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_rd,
   input logic       acc_wr,
   input logic [7:0] acc_wdata,
   input logic       granted,
   input logic       busy_err,
   input logic       inval_err,
   input logic       done
);
   a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_rd && acc_wr));

   a_r10_no_back_to_back_rd: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> !acc_rd);

   a_r10_write_codes: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |-> (acc_wdata == 8'h02 || acc_wdata == 8'h20));

   a_r7_yield_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_wdata == 8'h20) |=> !granted);

   a_r6_busy_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
      busy_err |-> !granted);

   a_r4_grant_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted) |-> done);

   a_r3_inval_keeps_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inval_err) |-> $stable(granted));
endmodule

bind tis_loc_arbiter tis_loc_arbiter_chk i_chk (
   .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
   .acc_wdata(acc_wdata), .granted(granted), .busy_err(busy_err),
   .inval_err(inval_err), .done(done)
);

// File: tb/test_tis_loc_arbiter.sv
`timescale 1ns/1ps

module tis_acc_model (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       rvalid,
   input  int         valid_after,
   input  int         act_after,
   input  logic       pending,
   input  logic       set_active,
   input  logic       clr_state,
   output int         rd_cnt,
   output int         wr_cnt,
   output logic [7:0] last_wr
);
   logic active, req_seen, act_now;
   int   polls;

   assign act_now = active || (req_seen && act_after != 0 && polls + 1 >= act_after);

   always @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0; rdata <= 8'h00; rd_cnt <= 0; wr_cnt <= 0; last_wr <= 8'h00;
         active <= 1'b0; req_seen <= 1'b0; polls <= 0;
      end else begin
         rvalid <= rd;
         if (clr_state) begin
            active <= 1'b0; req_seen <= 1'b0; polls <= 0;
         end else if (set_active) active <= 1'b1;
         if (rd) begin
            rd_cnt <= rd_cnt + 1;
            rdata  <= ((rd_cnt >= valid_after) ? 8'h80 : 8'h00) |
                      (act_now ? 8'h20 : 8'h00) | (pending ? 8'h04 : 8'h00);
            if (req_seen) begin
               polls <= polls + 1;
               if (act_now) begin active <= 1'b1; req_seen <= 1'b0; end
            end
         end
         if (wr) begin
            wr_cnt  <= wr_cnt + 1;
            last_wr <= wdata;
            if (wdata == 8'h02) begin req_seen <= 1'b1; polls <= 0; end
            if (wdata == 8'h20) active <= 1'b0;
         end
      end
   end
endmodule

module test_tis_loc_arbiter;
   localparam int LOC_W = 3;
   localparam int GAP   = 4;
   localparam int TMO   = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             acq = 1'b0, rel = 1'b0;
   logic [LOC_W-1:0] loc = '0;
   logic             acc_rd, acc_wr, acc_rvalid;
   logic [7:0]       acc_wdata, acc_rdata;
   logic             granted, busy_err, inval_err, done;
   int               a_act_after = 1;
   logic             a_pend = 1'b0, a_set = 1'b0, a_clr = 1'b0;
   int               rd_cnt, wr_cnt;
   logic [7:0]       last_wr;

   logic       b_rd, b_wr, b_rvalid, b_granted, b_busy, b_inval, b_done;
   logic [7:0] b_wdata, b_rdata, b_last;
   int         b_rd_cnt, b_wr_cnt;

   int n_chk = 0, n_err = 0, cyc = 0, done_seen = 0, clash = 0;

   tis_loc_arbiter #(.LOC_W(LOC_W), .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .STARTUP_TRIES(20))
   i_tis_loc_arbiter (
      .clk(clk), .rst_n(rst_n), .cmd_acquire(acq), .cmd_release(rel), .cmd_loc(loc),
      .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .acc_rvalid(acc_rvalid), .granted(granted), .busy_err(busy_err),
      .inval_err(inval_err), .done(done)
   );

   tis_acc_model i_dev_a (
      .clk(clk), .rst_n(rst_n), .rd(acc_rd), .wr(acc_wr), .wdata(acc_wdata),
      .rdata(acc_rdata), .rvalid(acc_rvalid), .valid_after(5), .act_after(a_act_after),
      .pending(a_pend), .set_active(a_set), .clr_state(a_clr),
      .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .last_wr(last_wr)
   );

   tis_loc_arbiter #(.LOC_W(LOC_W), .POLL_GAP(GAP), .TIMEOUT_CYC(TMO), .STARTUP_TRIES(3))
   i_tis_loc_arbiter_b (
      .clk(clk), .rst_n(rst_n), .cmd_acquire(1'b0), .cmd_release(1'b0), .cmd_loc('0),
      .acc_rd(b_rd), .acc_wr(b_wr), .acc_wdata(b_wdata), .acc_rdata(b_rdata),
      .acc_rvalid(b_rvalid), .granted(b_granted), .busy_err(b_busy),
      .inval_err(b_inval), .done(b_done)
   );

   tis_acc_model i_dev_b (
      .clk(clk), .rst_n(rst_n), .rd(b_rd), .wr(b_wr), .wdata(b_wdata),
      .rdata(b_rdata), .rvalid(b_rvalid), .valid_after(100000), .act_after(0),
      .pending(1'b0), .set_active(1'b0), .clr_state(1'b0),
      .rd_cnt(b_rd_cnt), .wr_cnt(b_wr_cnt), .last_wr(b_last)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && done) done_seen <= done_seen + 1;
      if (rst_n && acc_rd && acc_wr) clash <= clash + 1;
   end

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      wait (cyc >= 150000);
      n_err++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      finish_run();
   end

   task automatic wait_done(int target);
      int k = 0;
      while (done_seen < target && k < 2000) begin
         @(negedge clk);
         k++;
      end
      if (done_seen < target) chk("R9", "done never came", done_seen, target);
   endtask

   task automatic run_cmd(bit a, bit r, int l);
      int target;
      target = done_seen + 1;
      @(negedge clk);
      acq = a; rel = r; loc = LOC_W'(l);
      @(negedge clk);
      acq = 1'b0; rel = 1'b0; loc = '0;
      wait_done(target);
   endtask

   task automatic prep_dev(bit act, int after, bit pend);
      @(negedge clk); a_clr = 1'b1;
      @(negedge clk); a_clr = 1'b0; a_set = act;
      @(negedge clk); a_set = 1'b0; a_act_after = after; a_pend = pend;
   endtask

   // 0 inval, 1 grant without write, 2 grant after request, 3 busy, 4 yield, 5 keep
   function automatic int exp_kind(bit is_acq, int l, bit act, int after, bit pend);
      if (!is_acq) return pend ? 4 : 5;
      if (l != 0)  return 0;
      if (act)     return 1;
      return (after != 0) ? 2 : 3;
   endfunction

   bit exp_g = 1'b0;

   task automatic check_kind(int kind, int wr0, string tag);
      case (kind)
         0: begin chk("R3", {tag, " inval"}, inval_err, 1); chk("R3", {tag, " no write"}, wr_cnt, wr0); end
         1: begin exp_g = 1; chk("R4", {tag, " no write"}, wr_cnt, wr0); end
         2: begin exp_g = 1; chk("R5", {tag, " one write"}, wr_cnt, wr0 + 1);
                  chk("R5", {tag, " wrote 0x02"}, last_wr, 8'h02); end
         3: begin exp_g = 0; chk("R6", {tag, " busy"}, busy_err, 1);
                  chk("R6", {tag, " wrote 0x02"}, last_wr, 8'h02); end
         4: begin exp_g = 0; chk("R7", {tag, " wrote 0x20"}, last_wr, 8'h20);
                  chk("R7", {tag, " one write"}, wr_cnt, wr0 + 1); end
         default: chk("R7", {tag, " no write"}, wr_cnt, wr0);
      endcase
      chk("R9", {tag, " granted"}, granted, exp_g);
      if (kind != 3) chk("R9", {tag, " busy clear"}, busy_err, 0);
      if (kind != 0) chk("R9", {tag, " inval clear"}, inval_err, 0);
   endtask

   initial begin
      int wr0, rd0, d0, t0;
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      chk("R1", "granted in reset", granted, 0);
      chk("R1", "busy in reset", busy_err, 0);
      chk("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "inval after reset", inval_err, 0);
      chk("R1", "granted after reset", granted, 0);

      // R2: command during startup is held; 6 startup reads, request, one poll
      a_act_after = 1;
      run_cmd(1, 0, 0);
      chk("R2", "reads through startup and acquire", rd_cnt, 8);
      chk("R5", "request written once", wr_cnt, 1);
      chk("R5", "granted after poll", granted, 1);
      exp_g = 1;

      // R4: already active
      prep_dev(1, 0, 0);
      wr0 = wr_cnt; rd0 = rd_cnt;
      run_cmd(1, 0, 0);
      check_kind(1, wr0, "active");
      chk("R4", "single read", rd_cnt, rd0 + 1);

      // R3: bad locality, no bus access
      rd0 = rd_cnt; wr0 = wr_cnt;
      run_cmd(1, 0, 5);
      check_kind(0, wr0, "loc5");
      chk("R3", "no read", rd_cnt, rd0);

      // R7: release without pending keeps grant and clears inval (R9)
      wr0 = wr_cnt;
      run_cmd(0, 1, 0);
      check_kind(5, wr0, "rel keep");

      prep_dev(1, 0, 1);
      wr0 = wr_cnt;
      run_cmd(0, 1, 0);
      check_kind(4, wr0, "rel yield");

      // R6: timeout window
      prep_dev(0, 0, 0);
      wr0 = wr_cnt; t0 = cyc;
      run_cmd(1, 0, 0);
      check_kind(3, wr0, "timeout");
      chk("R6", "not before timeout", (cyc - t0) >= TMO, 1);
      chk("R6", "not long after timeout", (cyc - t0) <= TMO + 20, 1);

      // R9: next command clears busy
      wr0 = wr_cnt;
      run_cmd(1, 0, 2);
      check_kind(0, wr0, "after busy");

      // R8: release held behind acquire
      prep_dev(0, 3, 1);
      wr0 = wr_cnt; d0 = done_seen;
      @(negedge clk); acq = 1'b1;
      @(negedge clk); acq = 1'b0; rel = 1'b1;
      @(negedge clk); rel = 1'b0;
      wait_done(d0 + 2);
      repeat (40) @(negedge clk);
      chk("R8", "two completions", done_seen, d0 + 2);
      chk("R8", "request then yield", wr_cnt, wr0 + 2);
      chk("R8", "last write yield", last_wr, 8'h20);
      chk("R8", "granted dropped", granted, 0);
      exp_g = 0;

      // R8: same-cycle tie, acquire taken
      prep_dev(1, 0, 1);
      wr0 = wr_cnt; d0 = done_seen;
      run_cmd(1, 1, 0);
      repeat (40) @(negedge clk);
      chk("R8", "tie one completion", done_seen, d0 + 1);
      chk("R8", "tie granted", granted, 1);
      chk("R8", "tie no write", wr_cnt, wr0);
      exp_g = 1;

      // R8: third command dropped while one is held
      prep_dev(0, 3, 0);
      d0 = done_seen;
      @(negedge clk); acq = 1'b1;
      @(negedge clk); acq = 1'b0; rel = 1'b1;
      @(negedge clk); rel = 1'b0; acq = 1'b1; loc = 3'd1;
      @(negedge clk); acq = 1'b0; loc = '0;
      wait_done(d0 + 2);
      repeat (60) @(negedge clk);
      chk("R8", "dropped third", done_seen, d0 + 2);
      chk("R8", "no inval from dropped", inval_err, 0);

      // random mix
      for (int it = 0; it < 30; it++) begin
         bit a, act, pend;
         int l, after, kind;
         a     = ($urandom % 3) != 0;
         l     = (($urandom % 4) == 0) ? 1 + ($urandom % 7) : 0;
         act   = $urandom % 2;
         after = $urandom % 4;
         pend  = $urandom % 2;
         prep_dev(act, after, pend);
         kind = exp_kind(a, l, act, after, pend);
         wr0  = wr_cnt;
         run_cmd(a, !a, l);
         check_kind(kind, wr0, "random");
      end

      chk("R10", "read and write together", clash, 0);

      // R2: second instance never sees valid
      chk("R2", "startup failure busy", b_busy, 1);
      chk("R2", "startup read count", b_rd_cnt, 3);
      chk("R2", "no startup write", b_wr_cnt, 0);
      chk("R2", "startup no grant", b_granted, 0);

      finish_run();
   end
endmodule